// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides one 32-bit integer by another and returns a quotient and a remainder. It is iterative: one trial subtraction per clock, one bit of quotient per step, with a single narrow subtractor shared by all steps. A single wide accumulator register carries the partial remainder in its upper part and collects quotient bits in its lower part. The dividend enters the lower part, and the whole register is shifted left once before the first trial. Each later step subtracts the divisor from the upper part and keeps the difference only when it is not negative, shifting in a 1 or a 0 quotient bit accordingly. Because the shift comes before the subtract, the remainder finishes one place too far left, so a last correction step moves only the upper part back by one.

A select input picks unsigned or two's-complement operation. Signed division runs the unsigned loop on operand magnitudes and then fixes signs: the quotient is negated when the operand signs differ and the remainder carries the sign of the dividend. A zero divisor is flagged and produces a fixed result with the same latency as a normal division. A pulse on `start` while idle launches a division; `busy` covers the run and `done` pulses once when the results are valid.

Top module: `restoring_divider`

## Requirements
- R1: After reset `busy`, `done` and `div_by_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 is accepted; `busy` is 1 from the next cycle, and `done` is 1 for exactly one cycle, W+1 clock edges after the accepting edge (33 for W=32), with `busy` 0 in that cycle.
- R3: With `is_signed`=0, both operands are unsigned W-bit values; `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor (e.g. 0xFFFFFFFF/1 gives 0xFFFFFFFF remainder 0).
- R4: With `is_signed`=1, operands are two's complement; the quotient is truncated toward zero (negative when the operand signs differ) and the remainder has the dividend's sign and a magnitude below that of the divisor (e.g. -7/2 gives -3 remainder -1).
- R5: Signed division of the most negative value 0x80000000 by -1 wraps to quotient 0x80000000 with remainder 0.
- R6: A divisor of 0 in either mode sets `div_by_zero` to 1 alongside `done`, gives `quotient` all ones and `remainder` equal to the dividend bits as supplied, with the R2 latency; otherwise `div_by_zero` is 0 with `done`.
- R7: A `start` sampled while `busy` is 1 is ignored; the running division completes at its original time with results of its original operands.
- R8: `quotient`, `remainder` and `div_by_zero` change only in the cycle `done` is 1 and hold until the next accepted division completes, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, accepted only while idle |
| is_signed | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend | input | W | Dividend, sampled on the accepting edge |
| divisor | input | W | Divisor, sampled on the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| div_by_zero | output | 1 | Divisor was zero for the last result |
| quotient | output | W | Quotient of the last division |
| remainder | output | W | Remainder of the last division |

## Verification
Operands are captured on the edge that accepts `start`; `busy` is due one cycle later, and `done`, `quotient`, `remainder` and `div_by_zero` are all due 33 edges after that accepting edge, then held. The bench drives inputs on falling edges and samples on falling edges, so it checks `busy` on the first falling edge after acceptance, confirms `done` stays low through the 32 intervening falling edges, reads all results on the 34th falling edge counted from the drive, and on the next falling edge confirms `done` has dropped and results have not moved. A second launch attempt is driven in mid-run to show it leaves both the timing and the results of the running division unchanged.

// File: rtl/div_pkg.sv
// Package: shared types for the restoring divider.
// Assumes: nothing beyond a standard elaboration order (compiled first).
package div_pkg;

    // Control phases of the iterative divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_sign_prep.sv
// Module: div_sign_prep
// Turns raw operands into magnitudes for the unsigned loop and records which
// final sign corrections are needed. Purely combinational.
// Assumes: in unsigned mode the operands are already magnitudes; the
// magnitude of the most negative value is its own bit pattern read unsigned.
module div_sign_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output logic         flip_quo,
    output logic         flip_rem,
    output logic         den_zero
);
    logic num_neg;
    logic den_neg;

    // Magnitudes and sign-correction flags from the operand signs.
    always_comb begin
        num_neg  = is_signed & num[W-1];
        den_neg  = is_signed & den[W-1];
        num_mag  = num_neg ? (~num + 1'b1) : num;
        den_mag  = den_neg ? (~den + 1'b1) : den;
        flip_quo = num_neg ^ den_neg;
        flip_rem = num_neg;
        den_zero = (den == '0);
    end
endmodule

// File: rtl/div_step.sv
// Module: div_step
// One restoring iteration on the accumulator: trial-subtract the divisor
// magnitude from the upper part, keep the difference when it is not negative,
// then shift the whole accumulator left with the new quotient bit.
// Assumes: accumulator is 2W+1 bits, upper part (W+1 bits) is below twice the
// divisor, which holds for every step after the initial left shift.
module div_step #(
    parameter int W = 32
) (
    input  logic [2*W:0]  acc_in,
    input  logic [W-1:0]  den_mag,
    output logic [2*W:0]  acc_out
);
    localparam int HW = W + 1;

    logic [HW-1:0] upper;
    logic [HW-1:0] diff;
    logic          fits;
    logic [W-1:0]  kept;

    // Trial subtraction, restore on borrow, shift with the quotient bit.
    always_comb begin
        upper   = acc_in[2*W:W];
        diff    = upper - {1'b0, den_mag};
        fits    = ~diff[HW-1];
        kept    = fits ? diff[W-1:0] : upper[W-1:0];
        acc_out = {kept, acc_in[W-1:0], fits};
    end
endmodule

// File: rtl/div_sign_fix.sv
// Module: div_sign_fix
// Applies the recorded sign corrections to the unsigned quotient and
// remainder, or substitutes the fixed zero-divisor result. Combinational.
// Assumes: flags were captured with the operands of the same division.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         flip_quo,
    input  logic         flip_rem,
    input  logic         den_zero,
    input  logic [W-1:0] num_raw,
    output logic [W-1:0] quo_final,
    output logic [W-1:0] rem_final
);
    // Select the zero-divisor result or the sign-corrected magnitudes.
    always_comb begin
        if (den_zero) begin
            quo_final = '1;
            rem_final = num_raw;
        end else begin
            quo_final = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
            rem_final = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
        end
    end
endmodule

// File: rtl/restoring_divider.sv
// Module: restoring_divider (top)
// Iterative restoring divider: one W+1-bit trial subtraction per clock into a
// merged remainder/quotient accumulator, shift-first ordering, a final
// correction step that realigns the remainder, and sign fix-up for signed mode.
// Latency is W+1 edges from the accepting edge to done, zero divisor included.
// Assumes: start is ignored while busy; results hold until the next done.
module restoring_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_by_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int AW = 2 * W + 1;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    div_state_e   state;
    logic [AW-1:0] acc;
    logic [AW-1:0] acc_next;
    logic [W-1:0]  den_q;
    logic [W-1:0]  num_raw_q;
    logic          flip_quo_q;
    logic          flip_rem_q;
    logic          den_zero_q;
    logic [CW-1:0] step_cnt;

    logic [W-1:0]  num_mag_c;
    logic [W-1:0]  den_mag_c;
    logic          flip_quo_c;
    logic          flip_rem_c;
    logic          den_zero_c;
    logic [W-1:0]  quo_fix_c;
    logic [W-1:0]  rem_fix_c;
    logic          accept;

    div_sign_prep #(.W(W)) u_prep (
        .is_signed (is_signed),
        .num       (dividend),
        .den       (divisor),
        .num_mag   (num_mag_c),
        .den_mag   (den_mag_c),
        .flip_quo  (flip_quo_c),
        .flip_rem  (flip_rem_c),
        .den_zero  (den_zero_c)
    );

    div_step #(.W(W)) u_step (
        .acc_in  (acc),
        .den_mag (den_q),
        .acc_out (acc_next)
    );

    // Correction: upper part shifted right by one is acc[2W:W+1].
    div_sign_fix #(.W(W)) u_fix (
        .quo_mag   (acc[W-1:0]),
        .rem_mag   (acc[AW-1:W+1]),
        .flip_quo  (flip_quo_q),
        .flip_rem  (flip_rem_q),
        .den_zero  (den_zero_q),
        .num_raw   (num_raw_q),
        .quo_final (quo_fix_c),
        .rem_final (rem_fix_c)
    );

    // Launch condition: request seen while no division is running.
    always_comb begin
        accept = start & (state == ST_IDLE);
    end

    // Busy covers the loop and the correction step.
    always_comb begin
        busy = (state != ST_IDLE);
    end

    // Phase sequencing and step counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    step_cnt <= '0;
                    if (accept) state <= ST_ITER;
                end
                ST_ITER: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Accumulator: load with the initial left shift, then one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (accept) begin
            acc <= {{W{1'b0}}, num_mag_c, 1'b0};
        end else if (state == ST_ITER) begin
            acc <= acc_next;
        end
    end

    // Operand-side state captured at launch for use during the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q      <= '0;
            num_raw_q  <= '0;
            flip_quo_q <= 1'b0;
            flip_rem_q <= 1'b0;
            den_zero_q <= 1'b0;
        end else if (accept) begin
            den_q      <= den_mag_c;
            num_raw_q  <= dividend;
            flip_quo_q <= flip_quo_c;
            flip_rem_q <= flip_rem_c;
            den_zero_q <= den_zero_c;
        end
    end

    // Result registers, written once in the correction step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else if (state == ST_FIX) begin
            quotient    <= quo_fix_c;
            remainder   <= rem_fix_c;
            div_by_zero <= den_zero_q;
        end
    end

    // One-cycle completion pulse following the correction step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state == ST_FIX);
        end
    end
endmodule

// File: rtl/restoring_divider_chk.sv
// Module: restoring_divider_chk
// Port-level checker for restoring_divider, bound to every instance.
// Keeps its own copy of the accepted operands and a latency counter.
module restoring_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_signed,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic         div_by_zero,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int LW = $clog2(W + 3) + 1;
    localparam logic [LW-1:0] LAT = LW'(W + 1);

    logic [W-1:0]  c_num;
    logic [W-1:0]  c_den;
    logic          c_sgn;
    logic [LW-1:0] lat;
    logic [2*W-1:0] recon;

    // Capture operands and restart the latency count on each accepted launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_num <= '0;
            c_den <= '0;
            c_sgn <= 1'b0;
            lat   <= '1;
        end else if (start && !busy) begin
            c_num <= dividend;
            c_den <= divisor;
            c_sgn <= is_signed;
            lat   <= '0;
        end else if (lat != '1) begin
            lat <= lat + 1'b1;
        end
    end

    // Unsigned reconstruction of the dividend from the outputs.
    always_comb begin
        recon = ({{W{1'b0}}, quotient} * {{W{1'b0}}, c_den}) + {{W{1'b0}}, remainder};
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == LAT) && !busy);
    p_unsigned_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !c_sgn && c_den != '0) |-> (recon == {{W{1'b0}}, c_num}) && (remainder < c_den));
    p_signed_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_sgn && c_den != '0) |-> (remainder == '0) || (remainder[W-1] == c_num[W-1]));
    p_zero_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_den == '0) |-> div_by_zero && (quotient == '1) && (remainder == c_num));
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_den != '0) |-> !div_by_zero);
    p_results_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(quotient) || !$stable(remainder) || !$stable(div_by_zero)) |-> done);
endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) u_chk (.*);

// File: tb/restoring_divider_tb.sv
`timescale 1ns/100ps
// Directed bench for restoring_divider; one task per scenario.
module restoring_divider_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic         div_by_zero;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    restoring_divider #(.W(W)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .is_signed (is_signed),
        .dividend (dividend), .divisor (divisor), .busy (busy), .done (done),
        .div_by_zero (div_by_zero), .quotient (quotient), .remainder (remainder)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Run one division and check timing, results and hold behaviour.
    task automatic do_div(input logic [W-1:0] a, input logic [W-1:0] d,
                          input logic sg, input string req, input bit intrude);
        logic [W-1:0] eq, er;
        logic edz;
        bit early;
        longint sa, sd;
        if (d == '0) begin
            eq = '1; er = a; edz = 1'b1;
        end else if (sg) begin
            sa = longint'($signed(a)); sd = longint'($signed(d));
            eq = W'(sa / sd); er = W'(sa % sd); edz = 1'b0;
        end else begin
            eq = a / d; er = a % d; edz = 1'b0;
        end
        @(negedge clk);
        dividend = a; divisor = d; is_signed = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after launch", W'(busy), W'(1));
        early = 0;
        for (int k = 2; k <= 33; k++) begin
            if (intrude && k == 4) begin
                dividend = a ^ 32'h5A5A_1234; divisor = d + 3; is_signed = ~sg; start = 1'b1;
            end
            if (intrude && k == 5) start = 1'b0;
            @(negedge clk);
            if (done) early = 1;
        end
        check(!early, intrude ? "R7" : "R2", "done before latency", W'(early), W'(0));
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R2", "done/busy at latency", {30'b0, done, busy}, 32'h2);
        check(quotient == eq, req, "quotient", quotient, eq);
        check(remainder == er, req, "remainder", remainder, er);
        check(div_by_zero == edz, "R6", "div_by_zero", W'(div_by_zero), W'(edz));
        dividend = ~a; divisor = ~d; is_signed = ~sg;
        @(negedge clk);
        check(done == 1'b0, "R2", "done single cycle", W'(done), W'(0));
        repeat (3) @(negedge clk);
        check(quotient == eq && remainder == er, "R8", "results hold", quotient, eq);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !div_by_zero, "R1", "flags after reset",
              {29'b0, busy, done, div_by_zero}, 32'h0);
        check(quotient == '0 && remainder == '0, "R1", "results after reset", quotient | remainder, '0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unsigned();
        do_div(32'd100, 32'd7, 1'b0, "R3", 0);
        do_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R3", 0);
        do_div(32'd5, 32'd9, 1'b0, "R3", 0);
        do_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3", 0);
        do_div(32'hFFFF_FFFE, 32'h8000_0001, 1'b0, "R3", 0);
        do_div(32'hDEAD_BEEF, 32'h0001_0003, 1'b0, "R3", 0);
    endtask

    task automatic t_signed();
        do_div(-32'sd7, 32'sd2, 1'b1, "R4", 0);
        do_div(32'sd7, -32'sd2, 1'b1, "R4", 0);
        do_div(-32'sd7, -32'sd2, 1'b1, "R4", 0);
        do_div(32'sd1000, 32'sd33, 1'b1, "R4", 0);
        do_div(-32'sd6, 32'sd3, 1'b1, "R4", 0);
    endtask

    task automatic t_overflow();
        do_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5", 0);
    endtask

    task automatic t_zero_divisor();
        do_div(32'd1234, 32'd0, 1'b0, "R6", 0);
        do_div(-32'sd5, 32'd0, 1'b1, "R6", 0);
    endtask

    task automatic t_start_while_busy();
        do_div(32'd999, 32'd10, 1'b0, "R7", 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_unsigned();
        t_signed();
        t_overflow();
        t_zero_divisor();
        t_start_while_busy();
        finish_run();
    end
endmodule